// File: doc/BRIEF.md
# Byte-wide SPI master with register interface

This block is a serial peripheral interface master that moves one byte at a time. Software reaches it through a small 32-bit register bus with a one-cycle registered read. A control register holds a six-bit clock-divide field and the clock polarity and phase bits. A system-control register enables master operation and holds the chip-select level, which software sets by hand. A write to the transmit register starts one full-duplex exchange: eight bits go out on MOSI, most significant first, while eight bits are captured from MISO.

The serial clock comes from a two-stage divider. The first stage is a coarse prescale of either PRE_LO or PRE_HI system clocks (16 and 128 by default), picked by one control bit. The second stage is an even divide of 2 to 64, set by a five-bit count. Software polls a busy flag and a receive-full flag in the status register. It then reads the captured byte from the receive register, and that read clears the receive-full flag.

Top module: `spim_top`

## Requirements
- R1: After a synchronous reset, all of the following hold. Status (0x04), control (0x00), second control (0x14) and receive (0x10) read 0. System control (0x08) reads 0x40. cs_n is 1 and sck is 0.
- R2: Control (0x00) bits [7:0] and second control (0x14) bits [7:0] read back as written, with their upper bits reading 0. Receive (0x10) bits [31:8] always read 0. A read returns data in the cycle after bus_re.
- R3: System-control bit 6 drives cs_n directly: 0 asserts it low and 1 releases it high. System-control bit 0 enables master mode, so writing 0x21 enables transfers with cs_n low. A transmit write (0x0C) while bit 0 is 0 is ignored: busy stays 0 and sck does not toggle.
- R4: Each sck half period lasts P*(n+1) system clocks. Here n is control bits [4:0], and P is PRE_HI when control bit 5 is 1 and PRE_LO when it is 0.
- R5: Outside a transfer, sck rests at the level of control bit 6 (CPOL).
- R6: A transfer makes exactly 8 sck cycles (16 edges) and sends the written byte MSB first. With control bit 7 (CPHA) at 0, MOSI holds bit 7 before the first edge and MISO is sampled on the leading (odd-numbered) edges.
- R7: With CPHA at 1, MOSI changes on the leading edges and MISO is sampled on the trailing edges. The byte sent and the byte received are both correct in all four CPOL/CPHA combinations.
- R8: Status bit 0 (busy) reads 1 from a transmit write until the last edge of that transfer. A transmit write while busy is 1 is ignored.
- R9: Status bit 2 (receive full) is set when a transfer completes. It is cleared by a read of the receive register, and also by writing 0 to status bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_re |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |

## Verification
The bench builds the block with PRE_LO=2 and PRE_HI=8. With these values one byte takes tens of cycles rather than thousands, so every CPOL/CPHA combination and both prescale branches can be run, each with a measured half period. A slave model on the serial pins shifts in its own byte and captures MOSI. A scoreboard queue supplies the expected values for the slave capture and for the receive register. Ignored writes, both while busy and with master mode off, are checked through the slave capture, the edge count and the status register.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int REG_ADDR_W = 5;
  localparam logic [REG_ADDR_W-1:0] A_CTRL   = 5'h00;
  localparam logic [REG_ADDR_W-1:0] A_STAT   = 5'h04;
  localparam logic [REG_ADDR_W-1:0] A_SYSCTL = 5'h08;
  localparam logic [REG_ADDR_W-1:0] A_TXD    = 5'h0C;
  localparam logic [REG_ADDR_W-1:0] A_RXD    = 5'h10;
  localparam logic [REG_ADDR_W-1:0] A_CTRL2  = 5'h14;

  typedef struct packed {
    logic       cpha;
    logic       cpol;
    logic       pre_hi;
    logic [4:0] div_n;
  } ctrl_t;

  localparam logic [7:0] SYSCTL_RST = 8'h40;
endpackage

// File: rtl/spim_clkgen.sv
module spim_clkgen #(
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 128
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       pre_hi,
  input  logic [4:0] div_n,
  output logic       tick
);
  localparam int MAXH = PRE_HI * 32;
  localparam int CW   = $clog2(MAXH + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] half;

  always_comb begin
    half = CW'((pre_hi ? PRE_HI : PRE_LO) * (int'(div_n) + 1));
  end

  assign tick = run && (cnt == half - CW'(1));

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + CW'(1);
  end

  assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (rst)
    (run && tick) |=> (cnt == '0));
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] tx_byte,
  input  logic          cpha,
  input  logic          cpol,
  input  logic          tick,
  input  logic          miso,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rx_byte,
  output logic          sck,
  output logic          mosi
);
  localparam int EDGES = 2 * DW;
  localparam int EW    = $clog2(EDGES);

  logic [DW-1:0] sh_tx, sh_rx;
  logic [EW-1:0] ecnt;
  logic          cpha_q;
  logic          lead, samp;

  assign lead = ~ecnt[0];
  assign samp = lead ^ cpha_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_tx <= '0; sh_rx <= '0; ecnt <= '0; cpha_q <= 1'b0;
      busy <= 1'b0; done <= 1'b0; rx_byte <= '0; sck <= 1'b0; mosi <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        sck <= cpol;
        if (start) begin
          busy   <= 1'b1;
          ecnt   <= '0;
          cpha_q <= cpha;
          if (!cpha) begin
            mosi  <= tx_byte[DW-1];
            sh_tx <= tx_byte << 1;
          end else begin
            sh_tx <= tx_byte;
          end
        end
      end else if (tick) begin
        sck  <= ~sck;
        ecnt <= ecnt + EW'(1);
        if (samp) begin
          sh_rx <= {sh_rx[DW-2:0], miso};
        end else begin
          mosi  <= sh_tx[DW-1];
          sh_tx <= sh_tx << 1;
        end
        if (ecnt == EW'(EDGES - 1)) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          rx_byte <= samp ? {sh_rx[DW-2:0], miso} : sh_rx;
        end
      end
    end
  end

  assert_start_clean_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (ecnt == '0));
  assert_mosi_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick) |=> $stable(mosi));
  assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int ADDR_W = REG_ADDR_W,
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);
  localparam int DW = 8;

  ctrl_t         ctrl;
  logic [7:0]    ctrl2;
  logic [7:0]    sysctl;
  logic          rx_full;
  logic          busy, done, tick, start;
  logic [DW-1:0] rx_byte;
  logic          rd_rx;

  assign start = bus_we && (bus_addr == A_TXD) && sysctl[0] && !busy;
  assign rd_rx = bus_re && (bus_addr == A_RXD);
  assign cs_n  = sysctl[6];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      ctrl2  <= '0;
      sysctl <= SYSCTL_RST;
    end else if (bus_we) begin
      case (bus_addr)
        A_CTRL:   ctrl   <= ctrl_t'(bus_wdata[7:0]);
        A_CTRL2:  ctrl2  <= bus_wdata[7:0];
        A_SYSCTL: sysctl <= bus_wdata[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                  rx_full <= 1'b0;
    else if (done)                            rx_full <= 1'b1;
    else if (rd_rx)                           rx_full <= 1'b0;
    else if (bus_we && bus_addr == A_STAT)    rx_full <= rx_full & bus_wdata[2];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_re) begin
      case (bus_addr)
        A_CTRL:   bus_rdata <= {24'd0, ctrl};
        A_STAT:   bus_rdata <= {29'd0, rx_full, 1'b0, busy};
        A_SYSCTL: bus_rdata <= {24'd0, sysctl};
        A_RXD:    bus_rdata <= {24'd0, rx_byte};
        A_CTRL2:  bus_rdata <= {24'd0, ctrl2};
        default:  bus_rdata <= '0;
      endcase
    end
  end

  spim_clkgen #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI)) u_clkgen (
    .clk(clk), .rst(rst), .run(busy), .pre_hi(ctrl.pre_hi),
    .div_n(ctrl.div_n), .tick(tick));

  spim_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst(rst), .start(start), .tx_byte(bus_wdata[DW-1:0]),
    .cpha(ctrl.cpha), .cpol(ctrl.cpol), .tick(tick), .miso(miso),
    .busy(busy), .done(done), .rx_byte(rx_byte), .sck(sck), .mosi(mosi));

  assert_rx_full_on_done_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> rx_full);
  assert_sck_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy) && $stable(ctrl.cpol) && !$past(start)) |-> (sck == ctrl.cpol));
  assert_no_start_off_R3: assert property (@(posedge clk) disable iff (rst)
    (!sysctl[0] && !busy) |=> !busy);
endmodule

// File: tb/test_spim_top.sv
module test_spim_top;
  logic clk = 1'b0, rst = 1'b1;
  logic [4:0] bus_addr = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic sck, mosi, cs_n;
  logic miso;

  always #2 clk = ~clk;

  spim_top #(.PRE_LO(2), .PRE_HI(8)) i_spim_top (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .mosi(mosi),
    .miso(miso), .cs_n(cs_n));

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_mosi_q[$];
  logic [7:0] exp_rx_q[$];

  logic m_cpha = 1'b0;
  logic [7:0] slv_sh = '0, slv_cap = '0;
  int k = 0, nsamp = 0, edges_total = 0;
  int gap = 0, last_gap = 0;
  logic sck_prev = 1'b0;
  assign miso = slv_sh[7];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // slave model and scoreboard monitor for the serial side
  always @(negedge clk) begin
    gap <= gap + 1;
    if (cs_n) begin
      k <= 0; nsamp <= 0;
    end else if (sck !== sck_prev) begin
      automatic bit lead = (k % 2) == 0;
      automatic bit samp = lead ^ m_cpha;
      edges_total <= edges_total + 1;
      if (k > 0) last_gap <= gap;
      gap <= 1;
      if (samp) begin
        slv_cap = {slv_cap[6:0], mosi};
        nsamp <= nsamp + 1;
        if (nsamp == 7) begin
          if (exp_mosi_q.size() == 0) chk(1'b0, "R8 unexpected byte", {24'd0, slv_cap}, 0);
          else begin
            automatic logic [7:0] e = exp_mosi_q.pop_front();
            chk(slv_cap == e, "R6/R7 mosi byte", {24'd0, slv_cap}, {24'd0, e});
          end
        end
      end else if (!(m_cpha && k == 0)) begin
        slv_sh <= {slv_sh[6:0], 1'b0};
      end
      k <= k + 1;
    end
    sck_prev <= sck;
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1'b1;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(5'h04, s);
      if (!s[0]) return;
    end
  endtask

  task automatic xfer(input logic [7:0] ctrl, input logic [7:0] tx, input logic [7:0] sb, input int half);
    logic [31:0] s, r;
    wr(5'h00, {24'd0, ctrl});
    m_cpha = ctrl[7];
    repeat (2) @(negedge clk);
    chk(sck == ctrl[6], "R5 idle level", {31'd0, sck}, {31'd0, ctrl[6]});
    slv_sh = sb;
    wr(5'h08, 32'h21);
    chk(cs_n == 1'b0, "R3 cs asserted", {31'd0, cs_n}, 0);
    exp_mosi_q.push_back(tx);
    exp_rx_q.push_back(sb);
    wr(5'h0C, {24'd0, tx});
    rd(5'h04, s);
    chk(s[0] == 1'b1, "R8 busy after write", s, 1);
    wait_idle();
    rd(5'h04, s);
    chk(s[2:0] == 3'b100, "R9 rx full set", s, 4);
    chk(last_gap == half, "R4 half period", last_gap, half);
    rd(5'h10, r);
    begin
      automatic logic [7:0] e = exp_rx_q.pop_front();
      chk(r == {24'd0, e}, "R6/R7 rx byte", r, {24'd0, e});
    end
    rd(5'h04, s);
    chk(s[2] == 1'b0, "R9 read clears full", s, 0);
    wr(5'h08, 32'h61);
    chk(cs_n == 1'b1, "R3 cs released", {31'd0, cs_n}, 1);
    repeat (2) @(negedge clk);
    chk(sck == ctrl[6], "R5 idle after", {31'd0, sck}, {31'd0, ctrl[6]});
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog R8 actual=%0d expected<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, s;
    int e0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 1'b1 && sck == 1'b0, "R1 pins", {30'd0, cs_n, sck}, 32'h2);
    rd(5'h04, d); chk(d == 0, "R1 status", d, 0);
    rd(5'h00, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(5'h08, d); chk(d == 32'h40, "R1 sysctl", d, 32'h40);
    rd(5'h10, d); chk(d == 0, "R1 rx", d, 0);
    rd(5'h14, d); chk(d == 0, "R1 ctrl2", d, 0);

    wr(5'h14, 32'hFFFF_FFA5); rd(5'h14, d); chk(d == 32'hA5, "R2 ctrl2", d, 32'hA5);
    wr(5'h00, 32'h1234_56C3); rd(5'h00, d); chk(d == 32'hC3, "R2 ctrl", d, 32'hC3);

    // R3: master mode off, transmit ignored
    wr(5'h00, 32'h00);
    wr(5'h08, 32'h40);
    e0 = edges_total;
    wr(5'h0C, 32'h5A);
    rd(5'h04, s); chk(s[0] == 1'b0, "R3 off no busy", s, 0);
    repeat (40) @(negedge clk);
    chk(edges_total == e0, "R3 off no sck", edges_total, e0);
    wr(5'h08, 32'h60);

    // four modes and divider settings (PRE_LO=2, PRE_HI=8)
    xfer(8'h00, 8'hA5, 8'h3C, 2);
    xfer(8'h02, 8'h96, 8'hC1, 6);
    xfer(8'h80, 8'h0F, 8'hE7, 2);
    xfer(8'h40, 8'h81, 8'h7E, 2);
    xfer(8'hC1, 8'h5A, 8'h99, 4);
    xfer(8'h21, 8'hF0, 8'h18, 16);

    // R8: second write while busy is ignored
    wr(5'h00, 32'h01);
    m_cpha = 1'b0;
    slv_sh = 8'h66;
    wr(5'h08, 32'h21);
    exp_mosi_q.push_back(8'hC3);
    e0 = edges_total;
    wr(5'h0C, 32'hC3);
    wr(5'h0C, 32'h24);
    wait_idle();
    repeat (4) @(negedge clk);
    chk(edges_total - e0 == 16, "R8 one transfer edges", edges_total - e0, 16);
    chk(exp_mosi_q.size() == 0, "R8 queue drained", exp_mosi_q.size(), 0);
    rd(5'h10, d); chk(d == 32'h66, "R8 rx unchanged by ignored write", d, 32'h66);

    // R9: status write of 0 clears rx full
    wr(5'h0C, 32'h11);
    wait_idle();
    rd(5'h04, s); chk(s[2] == 1'b1, "R9 full again", s, 4);
    wr(5'h04, 32'h0);
    rd(5'h04, s); chk(s == 0, "R9 status write clears", s, 0);
    wr(5'h08, 32'h61);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule